// File: doc/BRIEF.md
# Paged Address Translator

This block sits between a 16-bit CPU address bus and a 20-bit physical bus. The virtual space is divided into sixteen 4 KB slots. The top four virtual address bits pick a slot, and the slot picks an 8-bit physical page from a small register table. The low twelve bits pass straight through. The topmost slot is wired to a fixed ROM page, so that vectors and switching code stay reachable whatever the table holds.

Software fills the table one entry at a time through an I/O register window, and can read every entry back. For a context switch, software first stores one table base address per process. It then writes a process number to a trigger register. The block takes the bus, holds the CPU off and copies fifteen page numbers from physical memory into the mappable entries, one byte per cycle. After that it releases the bus.

Top module: `page_xlate_unit`

## Requirements
- R1: `phys_addr_o` equals {page of slot `cpu_addr_i[15:12]`, `cpu_addr_i[11:0]`} in the same cycle, with no register on the path, for slots 0 to 14.
- R2: Slot 15 always yields page `ROM_PAGE` (default 0xFF). A write to register offset 0x0F has no effect, and reading offset 0x0F returns `ROM_PAGE`.
- R3: After reset, slot n maps to page n for n = 0 to 14, every process base reads 0, and `cpu_hold_o` is low.
- R4: A write with `reg_sel_i` and `reg_we_i` high to offset n (0x00 to 0x0E) sets entry n to `reg_wdata_i` from the next cycle. Reading offset n returns that entry.
- R5: The base of process p (p < `NPROC`) has its low byte at offset 0x10+2p and its high byte at offset 0x11+2p. Both bytes are writable and readable.
- R6: A write of value p < `NPROC` to offset 0x20 raises `cpu_hold_o` from the next cycle, for exactly 15 cycles. In the k-th of these cycles (k = 0 to 14), `ldr_addr_o` = {base_p, k[3:0]}, and entry k takes `ldr_rdata_i` at the end of that cycle.
- R7: A trigger value of `NPROC` or more starts no reload. While a reload runs, every register write is ignored, including a further trigger.
- R8: `ldr_rd_o` is high exactly while a reload runs.
- R9: Offset 0x21 reads {7'b0, busy}. Unmapped offsets, and any read with `reg_sel_i` low, return 0.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU virtual address |
| phys_addr_o | output | 20 | Translated physical address |
| reg_sel_i | input | 1 | Register window select |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| cpu_hold_o | output | 1 | Holds the CPU off the bus during a reload |
| ldr_rd_o | output | 1 | Loader memory read strobe |
| ldr_addr_o | output | 20 | Loader physical read address |
| ldr_rdata_i | input | 8 | Loader read data, valid in the same cycle |

## Verification
The assertions assume that memory returns `ldr_rdata_i` in the same cycle as the loader address, and that reset is asynchronous and active low. The bench meets the first assumption by driving `ldr_rdata_i` combinationally from `ldr_addr_o` through a fixed address hash. The stimulus also sends register writes and extra triggers while `cpu_hold_o` is high, so the bench confirms that the block discards them rather than relying on the CPU to stay quiet.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam int VA_W   = 16;
  localparam int OFS_W  = 12;
  localparam int PAGE_W = 8;
  localparam int PA_W   = OFS_W + PAGE_W;
  localparam int NSLOT  = 1 << (VA_W - OFS_W);
  localparam int SW     = VA_W - OFS_W;
  localparam int BASE_W = 16;
  localparam int RA_W   = 6;
  localparam logic [RA_W-1:0] RA_TRIG = 6'h20;
  localparam logic [RA_W-1:0] RA_STAT = 6'h21;
endpackage

// File: rtl/pxu_map_table.sv
module pxu_map_table
  import pxu_pkg::*;
#(
  parameter logic [PAGE_W-1:0] ROM_PAGE = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SW-1:0]     slot_i,
  input  logic [SW-1:0]     rd_idx_i,
  input  logic              cpu_we_i,
  input  logic [SW-1:0]     cpu_idx_i,
  input  logic [PAGE_W-1:0] cpu_data_i,
  input  logic              ld_we_i,
  input  logic [SW-1:0]     ld_idx_i,
  input  logic [PAGE_W-1:0] ld_data_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [PAGE_W-1:0] rd_page_o
);
  localparam logic [SW-1:0] LAST = SW'(NSLOT - 1);

  logic [PAGE_W-1:0] ent_q [NSLOT-1];

  // entries 0..NSLOT-2 only; the top slot is never stored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < NSLOT - 1; g++) ent_q[g] <= PAGE_W'(g);
    end else begin
      for (int g = 0; g < NSLOT - 1; g++) begin
        if (ld_we_i && ld_idx_i == SW'(g))        ent_q[g] <= ld_data_i;
        else if (cpu_we_i && cpu_idx_i == SW'(g)) ent_q[g] <= cpu_data_i;
      end
    end
  end

  always_comb begin
    page_o    = ROM_PAGE;
    rd_page_o = ROM_PAGE;
    for (int g = 0; g < NSLOT - 1; g++) begin
      if (slot_i == SW'(g))   page_o    = ent_q[g];
      if (rd_idx_i == SW'(g)) rd_page_o = ent_q[g];
    end
    if (slot_i == LAST)   page_o    = ROM_PAGE;
    if (rd_idx_i == LAST) rd_page_o = ROM_PAGE;
  end
endmodule

// File: rtl/pxu_ctx_loader.sv
module pxu_ctx_loader
  import pxu_pkg::*;
#(
  parameter int NPROC = 4,
  localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int AW = BASE_W + SW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic [PW-1:0]     base_proc_i,
  input  logic              base_hi_i,
  input  logic [7:0]        base_data_i,
  input  logic [PW-1:0]     rd_proc_i,
  input  logic              rd_hi_i,
  output logic [7:0]        rd_byte_o,
  input  logic              trig_i,
  input  logic [PW-1:0]     trig_proc_i,
  input  logic [PAGE_W-1:0] ldr_rdata_i,
  output logic              busy_o,
  output logic              ld_we_o,
  output logic [SW-1:0]     ld_idx_o,
  output logic [PAGE_W-1:0] ld_data_o,
  output logic [AW-1:0]     ldr_addr_o
);
  localparam logic [SW-1:0] LAST_IDX = SW'(NSLOT - 2);

  logic [BASE_W-1:0] base_q [NPROC];
  logic              busy_q;
  logic [SW-1:0]     idx_q;
  logic [PW-1:0]     proc_q;

  for (genvar p = 0; p < NPROC; p++) begin : g_base
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) base_q[p] <= '0;
      else if (base_we_i && base_proc_i == PW'(p)) begin
        if (base_hi_i) base_q[p][15:8] <= base_data_i;
        else           base_q[p][7:0]  <= base_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      proc_q <= '0;
    end else if (busy_q) begin
      if (idx_q == LAST_IDX) busy_q <= 1'b0;
      else                   idx_q  <= idx_q + 1'b1;
    end else if (trig_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      proc_q <= trig_proc_i;
    end
  end

  assign rd_byte_o  = rd_hi_i ? base_q[rd_proc_i][15:8] : base_q[rd_proc_i][7:0];
  assign busy_o     = busy_q;
  assign ld_we_o    = busy_q;
  assign ld_idx_o   = idx_q;
  assign ld_data_o  = ldr_rdata_i;
  assign ldr_addr_o = {base_q[proc_q], idx_q};
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
  import pxu_pkg::*;
#(
  parameter int NPROC = 4,
  parameter logic [7:0] ROM_PAGE = 8'hFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] cpu_addr_i,
  output logic [19:0] phys_addr_o,
  input  logic        reg_sel_i,
  input  logic        reg_we_i,
  input  logic [5:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  output logic        cpu_hold_o,
  output logic        ldr_rd_o,
  output logic [19:0] ldr_addr_o,
  input  logic [7:0]  ldr_rdata_i
);
  localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1;

  logic              busy;
  logic              wr_ok, tab_hit, base_hit, tab_we, base_we, trig;
  logic [PW-1:0]     base_proc, trig_proc;
  logic [PAGE_W-1:0] page, rd_page, base_byte;
  logic              ld_we;
  logic [SW-1:0]     ld_idx;
  logic [PAGE_W-1:0] ld_data;

  assign wr_ok     = reg_sel_i && reg_we_i && !busy;
  assign tab_hit   = reg_addr_i[5:4] == 2'b00;
  assign base_hit  = reg_addr_i[5:4] == 2'b01 && int'(reg_addr_i[3:1]) < NPROC;
  assign tab_we    = wr_ok && tab_hit;
  assign base_we   = wr_ok && base_hit;
  assign trig      = wr_ok && reg_addr_i == RA_TRIG && int'(reg_wdata_i) < NPROC;
  assign base_proc = PW'(reg_addr_i[3:1]);
  assign trig_proc = PW'(reg_wdata_i);

  pxu_map_table #(.ROM_PAGE(ROM_PAGE)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slot_i     (cpu_addr_i[VA_W-1:OFS_W]),
    .rd_idx_i   (reg_addr_i[SW-1:0]),
    .cpu_we_i   (tab_we),
    .cpu_idx_i  (reg_addr_i[SW-1:0]),
    .cpu_data_i (reg_wdata_i),
    .ld_we_i    (ld_we),
    .ld_idx_i   (ld_idx),
    .ld_data_i  (ld_data),
    .page_o     (page),
    .rd_page_o  (rd_page)
  );

  pxu_ctx_loader #(.NPROC(NPROC)) u_loader (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .base_we_i   (base_we),
    .base_proc_i (base_proc),
    .base_hi_i   (reg_addr_i[0]),
    .base_data_i (reg_wdata_i),
    .rd_proc_i   (base_proc),
    .rd_hi_i     (reg_addr_i[0]),
    .rd_byte_o   (base_byte),
    .trig_i      (trig),
    .trig_proc_i (trig_proc),
    .ldr_rdata_i (ldr_rdata_i),
    .busy_o      (busy),
    .ld_we_o     (ld_we),
    .ld_idx_o    (ld_idx),
    .ld_data_o   (ld_data),
    .ldr_addr_o  (ldr_addr_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_sel_i) begin
      if (tab_hit)                     reg_rdata_o = rd_page;
      else if (base_hit)               reg_rdata_o = base_byte;
      else if (reg_addr_i == RA_STAT)  reg_rdata_o = {7'b0, busy};
    end
  end

  assign phys_addr_o = {page, cpu_addr_i[OFS_W-1:0]};
  assign cpu_hold_o  = busy;
  assign ldr_rd_o    = busy;
endmodule

// File: rtl/page_xlate_unit_chk.sv
module page_xlate_unit_chk #(
  parameter int NPROC = 4,
  parameter logic [7:0] ROM_PAGE = 8'hFF
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] cpu_addr_i,
  input logic [19:0] phys_addr_o,
  input logic        reg_sel_i,
  input logic        reg_we_i,
  input logic [5:0]  reg_addr_i,
  input logic [7:0]  reg_wdata_i,
  input logic        cpu_hold_o,
  input logic        ldr_rd_o,
  input logic [19:0] ldr_addr_o
);
  logic [7:0] run_q;
  logic       trig_wr;

  assign trig_wr = reg_sel_i && reg_we_i && reg_addr_i == 6'h20 && !cpu_hold_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= '0;
    else if (ldr_rd_o) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  AST_OFS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_addr_o[11:0] == cpu_addr_i[11:0]); // R1
  AST_ROM_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_addr_i[15:12] == 4'hF |-> phys_addr_o[19:12] == ROM_PAGE); // R2
  AST_TRIG_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_wr && int'(reg_wdata_i) < NPROC |=> cpu_hold_o); // R6
  AST_FIRST_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ldr_rd_o) |-> ldr_addr_o[3:0] == 4'h0); // R6
  AST_LDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ldr_rd_o && $past(ldr_rd_o) |-> ldr_addr_o == $past(ldr_addr_o) + 20'd1); // R6
  AST_RUN_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ldr_rd_o |-> run_q <= 8'd14); // R6
  AST_RUN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ldr_rd_o) |-> $past(run_q) == 8'd14); // R6
  AST_BAD_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_wr && int'(reg_wdata_i) >= NPROC |=> !cpu_hold_o); // R7
endmodule

bind page_xlate_unit page_xlate_unit_chk #(.NPROC(NPROC), .ROM_PAGE(ROM_PAGE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_addr_i  (cpu_addr_i),
  .phys_addr_o (phys_addr_o),
  .reg_sel_i   (reg_sel_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .cpu_hold_o  (cpu_hold_o),
  .ldr_rd_o    (ldr_rd_o),
  .ldr_addr_o  (ldr_addr_o)
);

// File: tb/page_xlate_unit_tb_top.sv
module page_xlate_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int NPROC = 4;
  localparam logic [7:0] ROM = 8'hFF;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [19:0] phys_addr;
  logic        reg_sel = 1'b0, reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        cpu_hold, ldr_rd;
  logic [19:0] ldr_addr;
  logic [7:0]  ldr_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_byte(logic [19:0] a);
    return (a[7:0] * 8'd5) ^ a[19:12] ^ 8'h3C;
  endfunction

  assign ldr_rdata = mem_byte(ldr_addr);

  page_xlate_unit #(.NPROC(NPROC), .ROM_PAGE(ROM)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_addr_i(cpu_addr), .phys_addr_o(phys_addr),
    .reg_sel_i(reg_sel), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .cpu_hold_o(cpu_hold),
    .ldr_rd_o(ldr_rd), .ldr_addr_o(ldr_addr), .ldr_rdata_i(ldr_rdata)
  );

  // behavioural reference model
  int m_tab[16];
  int m_base[NPROC];
  bit m_busy;
  int m_idx, m_proc;

  function automatic logic [19:0] m_ldr_addr();
    return 20'((m_base[m_proc] << 4) + m_idx);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 16; i++) m_tab[i] = (i == 15) ? int'(ROM) : i;
      for (int p = 0; p < NPROC; p++) m_base[p] = 0;
      m_busy = 0; m_idx = 0; m_proc = 0;
    end else if (m_busy) begin
      m_tab[m_idx] = int'(mem_byte(m_ldr_addr()));
      if (m_idx == 14) m_busy = 0;
      else m_idx++;
    end else if (reg_sel && reg_we) begin
      int ra;
      ra = int'(reg_addr);
      if (ra < 15) m_tab[ra] = int'(reg_wdata);
      else if (ra >= 16 && ra < 16 + 2*NPROC) begin
        if (ra % 2 == 1) m_base[(ra-16)/2] = (m_base[(ra-16)/2] & 'hFF) | (int'(reg_wdata) << 8);
        else             m_base[(ra-16)/2] = (m_base[(ra-16)/2] & 'hFF00) | int'(reg_wdata);
      end else if (ra == 32 && int'(reg_wdata) < NPROC) begin
        m_busy = 1; m_idx = 0; m_proc = int'(reg_wdata);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      int slot, ra, ex;
      string t;
      slot = int'(cpu_addr[15:12]);
      ex = (slot == 15) ? int'(ROM) : m_tab[slot];
      chk((slot == 15) ? "R2 phys" : "R1 phys", 32'(phys_addr), 32'((ex << 12) | int'(cpu_addr[11:0])));
      ra = int'(reg_addr);
      ex = 0; t = "R9 rdata";
      if (reg_sel) begin
        if (ra < 15) begin ex = m_tab[ra]; t = "R4 rdata"; end
        else if (ra == 15) begin ex = int'(ROM); t = "R2 rdata"; end
        else if (ra >= 16 && ra < 16 + 2*NPROC) begin
          ex = (ra % 2 == 1) ? (m_base[(ra-16)/2] >> 8) & 'hFF : m_base[(ra-16)/2] & 'hFF;
          t = "R5 rdata";
        end else if (ra == 33) ex = m_busy ? 1 : 0;
      end
      chk(t, 32'(reg_rdata), 32'(ex));
      chk("R6 hold", 32'(cpu_hold), 32'(m_busy));
      chk("R8 ldr_rd", 32'(ldr_rd), 32'(m_busy));
      if (m_busy) chk("R6 ldr_addr", 32'(ldr_addr), 32'(m_ldr_addr()));
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(int ra, int wd);
    reg_sel = 1; reg_we = 1; reg_addr = 6'(ra); reg_wdata = 8'(wd);
    cyc();
    reg_sel = 0; reg_we = 0;
  endtask

  task automatic rd(int ra);
    reg_sel = 1; reg_we = 0; reg_addr = 6'(ra);
    cyc();
    reg_sel = 0;
  endtask

  task automatic sweep(int seed);
    for (int i = 0; i < 16; i++) begin
      cpu_addr = 16'((i << 12) | ((i * 37 + seed) & 'hFFF));
      cyc();
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40 && cpu_hold; i++) cyc();
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R3: flat map after reset, bases zero, not holding
    for (int s = 0; s < 15; s++) begin
      cpu_addr = 16'((s << 12) | 'h5A5);
      #1 chk("R3 flat map", 32'(phys_addr), 32'((s << 12) | 'h5A5));
    end
    reg_sel = 1; reg_addr = 6'h13;
    #1 chk("R3 base zero", 32'(reg_rdata), 0);
    reg_sel = 0;
    chk("R3 hold low", 32'(cpu_hold), 0);
    cyc();
    sweep(3);
    // R4 table writes and readback, R2 slot 15 write ignored
    for (int i = 0; i < 16; i++) wr(i, 'h40 + i * 3);
    for (int i = 0; i < 16; i++) rd(i);
    sweep(100);
    // R5 bases
    wr(16, 'h34); wr(17, 'h12); wr(18, 'hCD); wr(19, 'hAB);
    wr(20, 'h01); wr(21, 'h00); wr(22, 'hFF); wr(23, 'hFF);
    for (int i = 16; i < 26; i++) rd(i);
    rd(33); rd(34); rd(63);
    // R6 reload of process 1, with R7 writes during it
    wr(32, 1);
    rd(33);
    wr(3, 'h77);
    wr(32, 2);
    wr(18, 'h00);
    sweep(55);
    wait_idle();
    rd(3);
    reg_sel = 1; reg_addr = 6'h03;
    #1 chk("R7 write during reload", 32'(reg_rdata), 32'(m_tab[3]));
    reg_addr = 6'h12;
    #1 chk("R7 base write during reload", 32'(reg_rdata), 32'h00CD);
    reg_sel = 0;
    sweep(7);
    // process 3 at top of memory
    wr(32, 3);
    wait_idle();
    sweep(900);
    // R7 bad process number
    wr(32, 7);
    chk("R7 bad trigger", 32'(cpu_hold), 0);
    cyc();
    chk("R7 bad trigger late", 32'(cpu_hold), 0);
    wr(32, 0);
    wait_idle();
    sweep(2000);
    wr(15, 0);
    rd(15);
    for (int i = 0; i < 16; i++) rd(i);
    cpu_addr = 16'hF123;
    cyc();
    finish_run();
  end
endmodule